// File: doc/BRIEF.md
# Serial Transceiver with Loopback and Single-Wire Modes

This block is an asynchronous serial transceiver for 8-bit frames with an optional parity bit. It has a small register file, a transmit state machine, a receive state machine and a pin-routing stage. The pin-routing stage picks the receiver's input and decides how the two serial pins are driven. The host writes a byte to the data register to send it. It reads the data register to take the last byte received, and reads the status register to see whether the transmitter is busy, whether a byte is waiting and whether that byte had errors. A baud tick at sixteen times the bit rate times both directions.

In normal mode the transmitter drives TXD and the receiver listens on RXD. In loop mode the receiver is cut off from RXD, and RXD becomes a general-purpose pin. A source bit then selects the receiver input: either the transmitter's output, looped back internally, or the TXD pin, which gives half-duplex operation on one wire. A TXD direction bit decides whether TXD carries the waveform, idles high or floats. An open-drain setting turns every driven high level into a released pin.

Transmitter states: TX_IDLE goes to TX_START when the data register is written while sending is enabled. TX_START goes to TX_DATA after one bit time. TX_DATA goes to TX_PAR after the eighth bit if parity is on, otherwise to TX_STOP. TX_PAR goes to TX_STOP, and TX_STOP goes back to TX_IDLE, each after one bit time.

Receiver states: RX_IDLE goes to RX_START when the line is low on a tick. RX_START goes to RX_DATA if the line is still low at mid-bit, and otherwise back to RX_IDLE. RX_DATA goes to RX_PAR or RX_STOP after eight samples. RX_PAR goes to RX_STOP. RX_STOP goes to RX_IDLE when the stop bit is high and to RX_RECOVER when it is low. RX_RECOVER goes to RX_IDLE once the line is high. Clearing the receive enable sends any receiver state to RX_IDLE.

Top module: `sdx_uart`

## Requirements
- R1: After reset the mode, control and status registers read 0x00, TXD is driven (txd_oe=1) high, and RXD is not driven (rxd_oe=0).
- R2: A write to the data register (address 2) while the transmitter is idle and the transmit enable (control bit 0) is 1 sends one frame, each bit lasting 16 baud ticks. The frame is a low start bit, the 8 data bits LSB first, and a high stop bit. Status bit 0 is 1 while the frame is being sent.
- R3: When mode bit 1 is set, a parity bit follows the data bits. Mode bit 0 = 0 gives even parity and mode bit 0 = 1 gives odd parity.
- R4: With loop mode off (mode bit 7 = 0) and the receive enable (control bit 1) set, the receiver samples rxd_in at mid-bit. A complete frame sets status bit 1 and makes the byte readable at address 2. Reading address 2 with reg_rd clears status bit 1.
- R5: With mode bit 7 = 1 and mode bit 5 = 0, the receiver takes the transmitter's own output internally and rxd_in is ignored. When the TXD direction bit (control bit 2) is 0, TXD is driven high for the whole frame.
- R6: With mode bits 7 and 5 both set, the receiver takes its input from txd_in. TXD floats (txd_oe=0) when control bit 2 is 0 and carries the transmit waveform when control bit 2 is 1. The receiver also receives the block's own transmitted frames.
- R7: In loop mode RXD is a general-purpose pin: rxd_oe follows control bit 3 and rxd_out follows control bit 4. In normal mode rxd_oe is 0.
- R8: With mode bit 6 set, neither pin is ever driven high. A pin whose value is 1 is released (oe=0), and a value of 0 is driven. This also applies to RXD used as a general-purpose output.
- R9: A frame whose stop bit is sampled low sets status bit 2. The receiver then waits for the line to go high before it looks for the next start bit.
- R10: With parity on, a frame whose parity bit does not match the selected parity sets status bit 3. A frame with correct parity clears it.
- R11: The mode register (address 0) keeps bits 7, 6, 5, 1 and 0 and reads 0 in the other bits. The control register (address 1) keeps bits 4:0. Both can be read and written at any time.
- R12: When control bit 0 is 0, a data write sends nothing and TXD stays high. When control bit 1 is 0, frames on the receiver input are not received and status bit 1 stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 mode, 1 control, 2 data, 3 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 2 clears the received flag) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd_in | input | 1 | Level sensed on the RXD pin |
| txd_in | input | 1 | Level sensed on the TXD pin |
| txd_out | output | 1 | Value for the TXD pin |
| txd_oe | output | 1 | TXD output enable (0 = high impedance) |
| rxd_out | output | 1 | Value for the RXD pin |
| rxd_oe | output | 1 | RXD output enable (0 = high impedance) |

## Verification
Most internal faults show at the pins or in the next status read. A transmitter in the wrong state shifts the TXD bit pattern within one bit time (64 clocks), so the bench samples each bit at mid-bit. A receiver that loses its bit count, or samples the wrong source, returns the wrong byte or a wrong error flag as soon as the frame's stop bit has been sampled. Faults in pin routing or in open-drain handling act in the same cycle as the register write, so the pin levels and output enables are checked right after each mode change. The case where loop mode is on and the source select is 0 deserves care. There TXD stays high, so an internal loopback fault shows only in the received byte.

// File: rtl/sdx_uart_pkg.sv
package sdx_uart_pkg;
    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_t;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_RECOVER} rx_state_t;

    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_CTL  = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    localparam int M_LOOP = 7;
    localparam int M_WOR  = 6;
    localparam int M_SRC  = 5;
    localparam int M_PEN  = 1;
    localparam int M_PODD = 0;
    localparam logic [7:0] MODE_MASK = 8'hE3;

    localparam int C_TXEN  = 0;
    localparam int C_RXEN  = 1;
    localparam int C_TXDIR = 2;
    localparam int C_RXDIR = 3;
    localparam int C_RXGPO = 4;
    localparam logic [7:0] CTL_MASK = 8'h1F;
endpackage

// File: rtl/sdx_uart_tx.sv
module sdx_uart_tx
    import sdx_uart_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic          busy,
    output logic          line_o
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW);

    tx_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] sh_q;
    logic          par_q;
    logic          bit_end;

    assign bit_end = tick && (cnt_q == CW'(OVS - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (load && en) state_d = TX_START;
            TX_START: if (bit_end) state_d = TX_DATA;
            TX_DATA:  if (bit_end && idx_q == IW'(DW - 1)) state_d = par_en ? TX_PAR : TX_STOP;
            TX_PAR:   if (bit_end) state_d = TX_STOP;
            TX_STOP:  if (bit_end) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
            par_q <= 1'b0;
        end else if (state_q == TX_IDLE) begin
            cnt_q <= '0;
            idx_q <= '0;
            if (load && en) begin
                sh_q  <= din;
                par_q <= (^din) ^ par_odd;
            end
        end else if (tick) begin
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
            if (bit_end && state_q == TX_DATA) begin
                sh_q  <= sh_q >> 1;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            TX_START: line_o = 1'b0;
            TX_DATA:  line_o = sh_q[0];
            TX_PAR:   line_o = par_q;
            default:  line_o = 1'b1;
        endcase
        busy = (state_q != TX_IDLE);
    end

    // R2: a frame always opens with a low start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !line_o);
    // R2: the line only moves on a baud tick while a frame is in flight
    p_line_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(line_o));
endmodule

// File: rtl/sdx_uart_rx.sv
module sdx_uart_rx
    import sdx_uart_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          line_i,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          ferr,
    output logic          perr
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW);

    rx_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] sh_q;
    logic          pbit_q;
    logic          s1_q, s2_q;
    logic          bit_end, mid_start;

    assign bit_end   = tick && (cnt_q == CW'(OVS - 1));
    assign mid_start = tick && (cnt_q == CW'(OVS / 2 - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= line_i;
            s2_q <= s1_q;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE:    if (tick && !s2_q) state_d = RX_START;
                RX_START:   if (mid_start) state_d = s2_q ? RX_IDLE : RX_DATA;
                RX_DATA:    if (bit_end && idx_q == IW'(DW - 1)) state_d = par_en ? RX_PAR : RX_STOP;
                RX_PAR:     if (bit_end) state_d = RX_STOP;
                RX_STOP:    if (bit_end) state_d = s2_q ? RX_IDLE : RX_RECOVER;
                RX_RECOVER: if (s2_q) state_d = RX_IDLE;
                default:    state_d = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
            pbit_q <= 1'b0;
            done   <= 1'b0;
            data   <= '0;
            ferr   <= 1'b0;
            perr   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_d != state_q) cnt_q <= '0;
            else if (tick)          cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
            if (state_q == RX_IDLE) idx_q <= '0;
            if (en && bit_end) begin
                unique case (state_q)
                    RX_DATA: begin
                        sh_q  <= {s2_q, sh_q[DW-1:1]};
                        idx_q <= idx_q + 1'b1;
                    end
                    RX_PAR:  pbit_q <= s2_q;
                    RX_STOP: begin
                        done <= 1'b1;
                        data <= sh_q;
                        ferr <= !s2_q;
                        perr <= par_en && ((^sh_q) ^ par_odd ^ pbit_q);
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: the completion pulse lasts exactly one cycle
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R12: a disabled receiver rests in its idle state
    p_disabled_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == RX_IDLE));
endmodule

// File: rtl/sdx_uart_pins.sv
module sdx_uart_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_en,
    input  logic wor_en,
    input  logic src_pin,
    input  logic txd_dir,
    input  logic rxd_dir,
    input  logic rxd_gpo,
    input  logic tx_line,
    input  logic rxd_in,
    input  logic txd_in,
    output logic rx_src,
    output logic txd_out,
    output logic txd_oe,
    output logic rxd_out,
    output logic rxd_oe
);
    logic tx_val, tx_drv, rx_val, rx_drv;

    always_comb begin
        if (!loop_en || txd_dir) begin
            tx_val = tx_line;
            tx_drv = 1'b1;
        end else begin
            tx_val = 1'b1;
            tx_drv = !src_pin;
        end
        rx_val = loop_en ? rxd_gpo : 1'b1;
        rx_drv = loop_en && rxd_dir;
        if (!loop_en) rx_src = rxd_in;
        else          rx_src = src_pin ? txd_in : tx_line;
        txd_out = tx_val;
        rxd_out = rx_val;
        txd_oe  = tx_drv && !(wor_en && tx_val);
        rxd_oe  = rx_drv && !(wor_en && rx_val);
    end

    // R8: open-drain pins never drive a high level
    p_wor_low_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wor_en |-> !(txd_oe && txd_out) && !(rxd_oe && rxd_out));
    // R6: single-wire with TXD as input releases the pin
    p_single_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && src_pin && !txd_dir) |-> !txd_oe);
    // R7: RXD is never driven outside loop mode
    p_rxd_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |-> !rxd_oe);
endmodule

// File: rtl/sdx_uart.sv
module sdx_uart
    import sdx_uart_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       baud_tick,
    input  logic       rxd_in,
    input  logic       txd_in,
    output logic       txd_out,
    output logic       txd_oe,
    output logic       rxd_out,
    output logic       rxd_oe
);
    logic [7:0]    mode_q, ctl_q;
    logic          rx_full_q;
    logic          tx_busy, tx_line, rx_src, rx_done, rx_ferr, rx_perr;
    logic [DW-1:0] rx_byte;
    logic          load, take;

    assign load = reg_wr && (reg_addr == A_DATA);
    assign take = reg_rd && (reg_addr == A_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            ctl_q     <= '0;
            rx_full_q <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_MODE) mode_q <= reg_wdata & MODE_MASK;
            if (reg_wr && reg_addr == A_CTL)  ctl_q  <= reg_wdata & CTL_MASK;
            if (rx_done)   rx_full_q <= 1'b1;
            else if (take) rx_full_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_MODE:  reg_rdata = mode_q;
            A_CTL:   reg_rdata = ctl_q;
            A_DATA:  reg_rdata = 8'(rx_byte);
            default: reg_rdata = {4'b0, rx_perr, rx_ferr, rx_full_q, tx_busy};
        endcase
    end

    sdx_uart_tx #(.DW(DW), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(ctl_q[C_TXEN]),
        .par_en(mode_q[M_PEN]), .par_odd(mode_q[M_PODD]), .load(load),
        .din(reg_wdata[DW-1:0]), .busy(tx_busy), .line_o(tx_line)
    );

    sdx_uart_rx #(.DW(DW), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(ctl_q[C_RXEN]),
        .par_en(mode_q[M_PEN]), .par_odd(mode_q[M_PODD]), .line_i(rx_src),
        .done(rx_done), .data(rx_byte), .ferr(rx_ferr), .perr(rx_perr)
    );

    sdx_uart_pins u_pins (
        .clk(clk), .rst_n(rst_n), .loop_en(mode_q[M_LOOP]), .wor_en(mode_q[M_WOR]),
        .src_pin(mode_q[M_SRC]), .txd_dir(ctl_q[C_TXDIR]), .rxd_dir(ctl_q[C_RXDIR]),
        .rxd_gpo(ctl_q[C_RXGPO]), .tx_line(tx_line), .rxd_in(rxd_in), .txd_in(txd_in),
        .rx_src(rx_src), .txd_out(txd_out), .txd_oe(txd_oe), .rxd_out(rxd_out), .rxd_oe(rxd_oe)
    );

    // R4: taking the byte clears the received flag unless a new frame lands
    p_rx_full_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !rx_done) |=> !rx_full_q);
    // R12: no frame starts while transmission is disabled
    p_tx_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[C_TXEN] && !tx_busy) |=> !tx_busy);
endmodule

// File: tb/sdx_uart_tb.sv
module sdx_uart_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       baud_tick = 1'b0;
    logic       rxd_drv = 1'b1;
    logic       txd_ext = 1'b1;
    logic       txd_in;
    logic       txd_out, txd_oe, rxd_out, rxd_oe;
    logic [1:0] tdiv = '0;
    int         n_chk = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tdiv      <= tdiv + 2'd1;
        baud_tick <= (tdiv == 2'd3);
    end

    assign txd_in = txd_oe ? txd_out : txd_ext;

    sdx_uart u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .baud_tick(baud_tick),
        .rxd_in(rxd_drv), .txd_in(txd_in), .txd_out(txd_out), .txd_oe(txd_oe),
        .rxd_out(rxd_out), .rxd_oe(rxd_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic bit_wait();
        repeat (64) @(negedge clk);
    endtask

    task automatic put(input logic on_txd, input logic v);
        if (on_txd) txd_ext = v;
        else        rxd_drv = v;
    endtask

    task automatic send_line(input logic on_txd, input logic [7:0] d, input logic wpar,
                             input logic pbit, input logic stopv);
        @(negedge clk);
        put(on_txd, 1'b0); bit_wait();
        for (int i = 0; i < 8; i++) begin
            put(on_txd, d[i]); bit_wait();
        end
        if (wpar) begin
            put(on_txd, pbit); bit_wait();
        end
        put(on_txd, stopv); bit_wait();
        put(on_txd, 1'b1);
        repeat (128) @(negedge clk);
    endtask

    task automatic cap_tx(input logic wpar, output logic [7:0] b, output logic pb,
                          output logic st, output logic found);
        found = 1'b0; b = '0; pb = 1'b0; st = 1'b0;
        for (int i = 0; i < 2000 && !found; i++) begin
            if (txd_out === 1'b0) found = 1'b1;
            else @(negedge clk);
        end
        if (found) begin
            repeat (32) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                bit_wait(); b[i] = txd_out;
            end
            if (wpar) begin
                bit_wait(); pb = txd_out;
            end
            bit_wait(); st = txd_out;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); chk("R1 mode reg", v, 8'h00);
        rd(2'd1, v); chk("R1 ctl reg", v, 8'h00);
        rd(2'd3, v); chk("R1 status", v, 8'h00);
        chk("R1 txd idle", {txd_oe, txd_out}, 2'b11);
        chk("R1 rxd oe", rxd_oe, 1'b0);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(2'd0, 8'hFF); rd(2'd0, v); chk("R11 mode readback", v, 8'hE3);
        wr(2'd1, 8'hFF); rd(2'd1, v); chk("R11 ctl readback", v, 8'h1F);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        rd(2'd0, v); chk("R11 mode cleared", v, 8'h00);
    endtask

    task automatic t_tx_normal();
        logic [7:0] v, b; logic pb, st, f;
        wr(2'd1, 8'h03);
        wr(2'd2, 8'h5A);
        rd(2'd3, v); chk("R2 busy during frame", v[0], 1'b1);
        cap_tx(1'b0, b, pb, st, f);
        chk("R2 start seen", f, 1'b1);
        chk("R2 data bits", b, 8'h5A);
        chk("R2 stop bit", st, 1'b1);
        repeat (80) @(negedge clk);
        rd(2'd3, v); chk("R2 idle after frame", v[0], 1'b0);
    endtask

    task automatic t_parity();
        logic [7:0] b; logic pb, st, f;
        wr(2'd0, 8'h02); wr(2'd2, 8'h07);
        cap_tx(1'b1, b, pb, st, f);
        chk("R3 even parity", {b, pb, st}, {8'h07, 1'b1, 1'b1});
        repeat (80) @(negedge clk);
        wr(2'd0, 8'h03); wr(2'd2, 8'h07);
        cap_tx(1'b1, b, pb, st, f);
        chk("R3 odd parity", {b, pb, st}, {8'h07, 1'b0, 1'b1});
        repeat (80) @(negedge clk);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_rx_normal();
        logic [7:0] v;
        wr(2'd1, 8'h03);
        send_line(1'b0, 8'hC3, 1'b0, 1'b0, 1'b1);
        rd(2'd3, v); chk("R4 rx full flag", v, 8'h02);
        rd(2'd2, v); chk("R4 rx byte", v, 8'hC3);
        rd(2'd3, v); chk("R4 flag cleared by read", v, 8'h00);
    endtask

    task automatic t_loop();
        logic [7:0] v; int lows;
        wr(2'd0, 8'h80); wr(2'd1, 8'h03);
        rxd_drv = 1'b0;
        chk("R5 txd idle high", {txd_oe, txd_out}, 2'b11);
        wr(2'd2, 8'h96);
        lows = 0;
        for (int i = 0; i < 10; i++) begin
            repeat (64) @(negedge clk);
            if (txd_out !== 1'b1) lows++;
        end
        chk("R5 txd held high in frame", lows, 0);
        repeat (200) @(negedge clk);
        rd(2'd3, v); chk("R5 loopback received", v, 8'h02);
        rd(2'd2, v); chk("R5 loopback byte", v, 8'h96);
        chk("R5 rxd not driven", rxd_oe, 1'b0);
        rxd_drv = 1'b1;
    endtask

    task automatic t_single();
        logic [7:0] v, b; logic pb, st, f;
        wr(2'd0, 8'hA0); wr(2'd1, 8'h03);
        chk("R6 txd floats", txd_oe, 1'b0);
        send_line(1'b1, 8'h3C, 1'b0, 1'b0, 1'b1);
        rd(2'd3, v); chk("R6 rx from txd pin", v, 8'h02);
        rd(2'd2, v); chk("R6 byte from txd pin", v, 8'h3C);
        wr(2'd1, 8'h07);
        chk("R6 txd driven when dir set", txd_oe, 1'b1);
        wr(2'd2, 8'hE1);
        cap_tx(1'b0, b, pb, st, f);
        chk("R6 waveform on txd", {b, st}, {8'hE1, 1'b1});
        repeat (200) @(negedge clk);
        rd(2'd3, v); chk("R6 own frame heard", v, 8'h02);
        rd(2'd2, v); chk("R6 own byte", v, 8'hE1);
    endtask

    task automatic t_gpio();
        wr(2'd0, 8'h80); wr(2'd1, 8'h18);
        chk("R7 gpio high", {rxd_oe, rxd_out}, 2'b11);
        wr(2'd1, 8'h08);
        chk("R7 gpio low", {rxd_oe, rxd_out}, 2'b10);
        wr(2'd0, 8'h00);
        chk("R7 normal mode input", rxd_oe, 1'b0);
    endtask

    task automatic t_wor();
        wr(2'd0, 8'hC0); wr(2'd1, 8'h18);
        chk("R8 gpio high released", rxd_oe, 1'b0);
        wr(2'd1, 8'h08);
        chk("R8 gpio low driven", {rxd_oe, rxd_out}, 2'b10);
        chk("R8 idle high txd released", txd_oe, 1'b0);
        wr(2'd0, 8'h40); wr(2'd1, 8'h01);
        chk("R8 normal idle released", txd_oe, 1'b0);
        wr(2'd2, 8'h00);
        repeat (8) @(negedge clk);
        chk("R8 start bit driven low", {txd_oe, txd_out}, 2'b10);
        repeat (800) @(negedge clk);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_errors();
        logic [7:0] v;
        wr(2'd1, 8'h02);
        send_line(1'b0, 8'h55, 1'b0, 1'b0, 1'b0);
        rd(2'd3, v); chk("R9 framing error", v, 8'h06);
        rd(2'd2, v); chk("R9 byte with bad stop", v, 8'h55);
        rd(2'd3, v); chk("R9 no spurious frame", v, 8'h04);
        wr(2'd0, 8'h02);
        send_line(1'b0, 8'h01, 1'b1, 1'b0, 1'b1);
        rd(2'd3, v); chk("R10 parity error", v, 8'h0A);
        rd(2'd2, v);
        send_line(1'b0, 8'h01, 1'b1, 1'b1, 1'b1);
        rd(2'd3, v); chk("R10 good parity clears", v, 8'h02);
        rd(2'd2, v); chk("R10 byte", v, 8'h01);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_enables();
        logic [7:0] v; int lows;
        wr(2'd1, 8'h00);
        wr(2'd2, 8'hFF);
        wr(2'd2, 8'h00);
        lows = 0;
        for (int i = 0; i < 12; i++) begin
            repeat (64) @(negedge clk);
            if (txd_out !== 1'b1) lows++;
        end
        chk("R12 no frame when tx disabled", lows, 0);
        rd(2'd3, v); chk("R12 tx not busy", v[0], 1'b0);
        send_line(1'b0, 8'h33, 1'b0, 1'b0, 1'b1);
        rd(2'd3, v); chk("R12 rx disabled no byte", v, 8'h00);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1-all: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_regs();
        t_tx_normal();
        t_parity();
        t_rx_normal();
        t_loop();
        t_single();
        t_gpio();
        t_wor();
        t_errors();
        t_enables();
        summary();
        $finish;
    end
endmodule